// File: doc/BRIEF.md
# 8B/10B Line Coder with Control Modes

The block turns one byte per clock into a 10-bit transmission character using the standard Fibre Channel 8B/10B code. It keeps a running disparity and picks the positive or negative form of each character from it. A flag chooses between data characters and control characters. When the link has nothing to send, an idle input makes the block emit the K28.5 comma, so the receiver stays aligned.

Two test and integration modes sit beside the coder. A violation request replaces the character with a fixed illegal pattern, which lets downstream error handling be exercised on demand. A bypass input sends a 10-bit raw word to the output unchanged, for systems that code or scramble outside this block. Every output is registered, and the word is presented with bit a at the most significant end, ready for a serializer that shifts bit a out first.

Top module: `line_coder_8b10b`

## Requirements
- R1: While rst_ni is low, code_o is all zeros and the running disparity is negative. The first character encoded after reset uses its negative-disparity form.
- R2: With ctrl_i low, byte HGF_EDCBA (x = bits 4:0, y = bits 7:5) is encoded as D.x.y from the data table. Examples: 0x00 gives 1001110100 at negative disparity and 0110001011 at positive. 0xB5 gives 1010101010. 0x07 at positive disparity gives 0001110100.
- R3: With ctrl_i high, the 12 valid control bytes are encoded from the control table. These bytes are 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC, 0xF7, 0xFB, 0xFD and 0xFE. Examples: 0xBC gives 0011111010 at negative disparity and 1100000101 at positive. 0xFC gives 0011111000. 0xF7 gives 1110101000.
- R4: With ctrl_i high and any other byte, the violation pattern is emitted and the running disparity is unchanged.
- R5: An idle slot (idle_i high) emits K28.5 for the current disparity, whatever data_i and ctrl_i hold. Idle yields to the violation request and to bypass.
- R6: viol_i high emits 1111100000 at negative disparity and 0000011111 at positive disparity. The running disparity is unchanged. The violation request overrides idle, control and data, and yields only to bypass.
- R7: bypass_i high registers raw_i to code_o unchanged and leaves the running disparity untouched. Bypass has the highest priority.
- R8: code_o[9] is bit a and code_o[0] is bit j. The character appears on code_o at the first rising clock edge after its inputs are applied, and not before.
- R9: After each encoded character, the running disparity flips exactly when the character has an unequal number of ones and zeros. A character started at negative disparity has 5 or 6 ones. A character started at positive disparity has 4 or 5 ones.
- R10: D.x.7 uses the alternate 0111/1000 sub-block in two cases: x is 17, 18 or 20 at negative mid-disparity, or x is 11, 13 or 14 at positive mid-disparity. Examples: 0xF1 at negative disparity gives 1000110111. 0xEB at positive disparity gives 1101001000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Byte to encode, bit 0 = A |
| ctrl_i | input | 1 | High selects the control table, low selects the data table |
| idle_i | input | 1 | High marks an empty slot, which sends K28.5 |
| viol_i | input | 1 | High forces the violation pattern |
| bypass_i | input | 1 | High passes raw_i through without coding |
| raw_i | input | 10 | Raw word for bypass, bit 9 = a |
| code_o | output | 10 | Registered character, bit 9 = a (sent first) |

## Verification
The idle slot, the violation request and bypass can all be active in the same cycle, and so can an idle slot and an invalid control byte. The bench raises these inputs together on one edge. It judges the result by the registered word against the priority order bypass, violation, idle, coder. It then sends a K28.5, whose polarity shows whether the losing paths disturbed the running disparity.

// File: rtl/line_coder_pkg.sv
package line_coder_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SYM_W  = 10;
  localparam int unsigned LO_W   = 5;
  localparam int unsigned HI_W   = BYTE_W - LO_W;
  localparam int unsigned SIX_W  = LO_W + 1;
  localparam int unsigned FOUR_W = HI_W + 1;

  localparam logic [BYTE_W-1:0] COMMA_BYTE = 8'hBC;  // K28.5
  localparam logic [SYM_W-1:0]  COMMA_NEG  = 10'b0011111010;

  typedef enum logic [1:0] {
    SRC_CODE,
    SRC_VIOL,
    SRC_RAW
  } src_e;
endpackage

// File: rtl/lc_ctrl_check.sv
module lc_ctrl_check
  import line_coder_pkg::*;
(
  input  logic [LO_W-1:0] lo_i,
  input  logic [HI_W-1:0] hi_i,
  output logic            valid_o
);
  always_comb begin
    valid_o = 1'b0;
    if (lo_i == 5'd28) valid_o = 1'b1;
    else if (hi_i == 3'd7 &&
             (lo_i == 5'd23 || lo_i == 5'd27 || lo_i == 5'd29 || lo_i == 5'd30))
      valid_o = 1'b1;
  end
endmodule

// File: rtl/lc_sub6.sv
module lc_sub6
  import line_coder_pkg::*;
(
  input  logic [LO_W-1:0]  lo_i,
  input  logic             k28_i,
  input  logic             rd_i,   // 1 = positive
  output logic [SIX_W-1:0] code_o, // [5] = a ... [0] = i
  output logic             rd_o
);
  logic [SIX_W-1:0] base;
  logic             unbal, alt;

  // negative-disparity column
  always_comb begin
    base = '0;
    case (lo_i)
      5'd0:  base = 6'b100111;
      5'd1:  base = 6'b011101;
      5'd2:  base = 6'b101101;
      5'd3:  base = 6'b110001;
      5'd4:  base = 6'b110101;
      5'd5:  base = 6'b101001;
      5'd6:  base = 6'b011001;
      5'd7:  base = 6'b111000;
      5'd8:  base = 6'b111001;
      5'd9:  base = 6'b100101;
      5'd10: base = 6'b010101;
      5'd11: base = 6'b110100;
      5'd12: base = 6'b001101;
      5'd13: base = 6'b101100;
      5'd14: base = 6'b011100;
      5'd15: base = 6'b010111;
      5'd16: base = 6'b011011;
      5'd17: base = 6'b100011;
      5'd18: base = 6'b010011;
      5'd19: base = 6'b110010;
      5'd20: base = 6'b001011;
      5'd21: base = 6'b101010;
      5'd22: base = 6'b011010;
      5'd23: base = 6'b111010;
      5'd24: base = 6'b110011;
      5'd25: base = 6'b100110;
      5'd26: base = 6'b010110;
      5'd27: base = 6'b110110;
      5'd28: base = 6'b001110;
      5'd29: base = 6'b101110;
      5'd30: base = 6'b011110;
      5'd31: base = 6'b101011;
      default: base = '0;
    endcase
    if (k28_i) base = 6'b001111;
  end

  assign unbal  = ($countones(base) != 3);
  assign alt    = unbal || (lo_i == 5'd7);
  assign code_o = (rd_i && alt) ? ~base : base;
  assign rd_o   = rd_i ^ unbal;
endmodule

// File: rtl/lc_sub4.sv
module lc_sub4
  import line_coder_pkg::*;
(
  input  logic [HI_W-1:0]   hi_i,
  input  logic [LO_W-1:0]   lo_i,
  input  logic              k_i,
  input  logic              rd_i,   // disparity after the six-bit block
  output logic [FOUR_W-1:0] code_o, // [3] = f ... [0] = j
  output logic              rd_o
);
  logic [FOUR_W-1:0] base;
  logic              use_alt7, unbal, flip;

  assign use_alt7 = k_i ||
                    (!rd_i && (lo_i == 5'd17 || lo_i == 5'd18 || lo_i == 5'd20)) ||
                    ( rd_i && (lo_i == 5'd11 || lo_i == 5'd13 || lo_i == 5'd14));

  always_comb begin
    base = '0;
    if (k_i) begin
      case (hi_i)
        3'd0: base = 4'b1011;
        3'd1: base = 4'b0110;
        3'd2: base = 4'b1010;
        3'd3: base = 4'b1100;
        3'd4: base = 4'b1101;
        3'd5: base = 4'b0101;
        3'd6: base = 4'b1001;
        default: base = 4'b0111;
      endcase
    end else begin
      case (hi_i)
        3'd0: base = 4'b1011;
        3'd1: base = 4'b1001;
        3'd2: base = 4'b0101;
        3'd3: base = 4'b1100;
        3'd4: base = 4'b1101;
        3'd5: base = 4'b1010;
        3'd6: base = 4'b0110;
        default: base = use_alt7 ? 4'b0111 : 4'b1110;
      endcase
    end
  end

  assign unbal  = ($countones(base) != 2);
  assign flip   = rd_i && (unbal || k_i || hi_i == 3'd3);
  assign code_o = flip ? ~base : base;
  assign rd_o   = rd_i ^ unbal;
endmodule

// File: rtl/line_coder_8b10b.sv
module line_coder_8b10b
  import line_coder_pkg::*;
#(
  parameter logic [SYM_W-1:0] VIOL_NEG = 10'b1111100000,
  parameter bit               RD_RESET = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              ctrl_i,
  input  logic              idle_i,
  input  logic              viol_i,
  input  logic              bypass_i,
  input  logic [SYM_W-1:0]  raw_i,
  output logic [SYM_W-1:0]  code_o
);
  localparam logic [SYM_W-1:0] VIOL_POS  = ~VIOL_NEG;
  localparam logic [SYM_W-1:0] COMMA_POS = ~COMMA_NEG;

  logic [BYTE_W-1:0] byte_eff;
  logic              ctrl_eff, k_valid, k28;
  logic [SIX_W-1:0]  code6;
  logic [FOUR_W-1:0] code4;
  logic              rd_q, rd_mid, rd_enc;
  logic [SYM_W-1:0]  enc_word, code_d, code_q;
  src_e              src;

  assign byte_eff = idle_i ? COMMA_BYTE : data_i;
  assign ctrl_eff = idle_i | ctrl_i;
  assign k28      = ctrl_eff && (byte_eff[LO_W-1:0] == 5'd28);

  lc_ctrl_check u_kchk (
    .lo_i   (byte_eff[LO_W-1:0]),
    .hi_i   (byte_eff[BYTE_W-1:LO_W]),
    .valid_o(k_valid)
  );

  lc_sub6 u_sub6 (
    .lo_i  (byte_eff[LO_W-1:0]),
    .k28_i (k28),
    .rd_i  (rd_q),
    .code_o(code6),
    .rd_o  (rd_mid)
  );

  lc_sub4 u_sub4 (
    .hi_i  (byte_eff[BYTE_W-1:LO_W]),
    .lo_i  (byte_eff[LO_W-1:0]),
    .k_i   (ctrl_eff),
    .rd_i  (rd_mid),
    .code_o(code4),
    .rd_o  (rd_enc)
  );

  assign enc_word = {code6, code4};

  always_comb begin
    if (bypass_i)                 src = SRC_RAW;
    else if (viol_i)              src = SRC_VIOL;
    else if (ctrl_eff && !k_valid) src = SRC_VIOL;
    else                          src = SRC_CODE;
  end

  always_comb begin
    case (src)
      SRC_RAW:  code_d = raw_i;
      SRC_VIOL: code_d = rd_q ? VIOL_POS : VIOL_NEG;
      default:  code_d = enc_word;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      rd_q   <= RD_RESET;
    end else begin
      code_q <= code_d;
      if (src == SRC_CODE) rd_q <= rd_enc;
    end
  end

  assign code_o = code_q;

  AST_RD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src == SRC_CODE) |-> (rd_q ? ($countones(enc_word) >= 4 && $countones(enc_word) <= 5)
                                : ($countones(enc_word) >= 5 && $countones(enc_word) <= 6))); // R9
  AST_RD_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src == SRC_CODE) |=> ((rd_q != $past(rd_q)) == ($past($countones(enc_word)) != 5))); // R9
  AST_RD_HOLD_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> $stable(rd_q)); // R7
  AST_BYPASS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> (code_o == $past(raw_i))); // R7
  AST_RD_HOLD_VIOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_i && !bypass_i) |=> $stable(rd_q)); // R6
  AST_VIOL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_i && !bypass_i) |=> (code_o == VIOL_NEG || code_o == VIOL_POS)); // R6
  AST_IDLE_COMMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && !viol_i && !bypass_i) |=> (code_o == COMMA_NEG || code_o == COMMA_POS)); // R5
  AST_BAD_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i && !idle_i && !viol_i && !bypass_i && !k_valid)
      |=> (code_o == VIOL_NEG || code_o == VIOL_POS)); // R4
endmodule

// File: tb/line_coder_8b10b_bench.sv
`timescale 1ns/1ps
module line_coder_8b10b_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic       ctrl_i = 1'b0, idle_i = 1'b0, viol_i = 1'b0, bypass_i = 1'b0;
  logic [9:0] raw_i = '0;
  logic [9:0] code_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [9:0] K285N = 10'b0011111010;
  localparam logic [9:0] K285P = 10'b1100000101;
  localparam logic [9:0] VN    = 10'b1111100000;
  localparam logic [9:0] VP    = 10'b0000011111;

  always #4 clk_i = ~clk_i;

  line_coder_8b10b u_line_coder_8b10b (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .ctrl_i(ctrl_i),
    .idle_i(idle_i), .viol_i(viol_i), .bypass_i(bypass_i), .raw_i(raw_i),
    .code_o(code_o)
  );

  task automatic check(input logic [9:0] exp, input string req);
    n_chk++;
    if (code_o !== exp) begin
      n_fail++;
      $display("FAIL %s: code_o=%b expected %b", req, code_o, exp);
    end
  endtask

  // applied at a falling edge, checked at the next falling edge
  task automatic step(input logic [7:0] d, input logic c, input logic i, input logic v,
                      input logic b, input logic [9:0] r, input logic [9:0] exp,
                      input string req);
    data_i = d; ctrl_i = c; idle_i = i; viol_i = v; bypass_i = b; raw_i = r;
    @(posedge clk_i);
    @(negedge clk_i);
    check(exp, req);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(10'b0, "R1 reset value");
    rst_ni = 1'b1;
  endtask

  task automatic t_data();  // starts at negative disparity
    step(8'h00, 0, 0, 0, 0, '0, 10'b1001110100, "R1 R2 D.0.0 neg");
    step(8'hB5, 0, 0, 0, 0, '0, 10'b1010101010, "R2 D.21.5");
    step(8'hF1, 0, 0, 0, 0, '0, 10'b1000110111, "R10 D.17.7 neg");
    step(8'hEB, 0, 0, 0, 0, '0, 10'b1101001000, "R10 D.11.7 pos");
  endtask

  task automatic t_ctrl();
    step(8'hBC, 1, 0, 0, 0, '0, K285N, "R3 K28.5 neg");
    step(8'h07, 0, 0, 0, 0, '0, 10'b0001110100, "R2 R9 D.7.0 pos");
    step(8'hFC, 1, 0, 0, 0, '0, 10'b0011111000, "R3 K28.7 neg");
    step(8'hF7, 1, 0, 0, 0, '0, 10'b1110101000, "R3 K23.7 neg");
  endtask

  task automatic t_bad_ctrl();
    step(8'h00, 1, 0, 0, 0, '0, VN, "R4 bad control neg");
    step(8'hBC, 1, 0, 0, 0, '0, K285N, "R4 disparity kept");
    step(8'hFF, 1, 0, 0, 0, '0, VP, "R4 bad control pos");
    step(8'hBC, 1, 0, 0, 0, '0, K285P, "R4 disparity kept pos");
  endtask

  task automatic t_idle();
    step(8'h00, 0, 1, 0, 0, '0, K285N, "R5 idle over data");
    step(8'hFC, 1, 1, 0, 0, '0, K285P, "R5 idle over control");
  endtask

  task automatic t_viol();
    step(8'h00, 0, 0, 1, 0, '0, VN, "R6 violation neg");
    step(8'hBC, 1, 0, 0, 0, '0, K285N, "R6 disparity kept");
    step(8'h00, 0, 0, 1, 0, '0, VP, "R6 violation pos");
    step(8'hBC, 1, 0, 0, 0, '0, K285P, "R6 disparity kept pos");
  endtask

  task automatic t_bypass();
    step(8'hBC, 1, 0, 0, 1, 10'b1100110001, 10'b1100110001, "R7 raw word");
    step(8'hBC, 1, 0, 0, 0, '0, K285N, "R7 disparity kept");
    step(8'h00, 0, 0, 0, 1, 10'h3FF, 10'h3FF, "R7 raw all ones");
    step(8'hBC, 1, 0, 0, 0, '0, K285P, "R7 disparity kept pos");
  endtask

  task automatic t_priority();
    step(8'h00, 0, 1, 1, 0, '0, VN, "R6 violation over idle");
    step(8'h00, 0, 1, 1, 1, 10'b0101010101, 10'b0101010101, "R7 bypass over all");
    step(8'h00, 1, 1, 0, 0, '0, K285N, "R5 idle over bad control");
  endtask

  task automatic t_latency();  // disparity now positive, code_o holds K28.5 neg
    data_i = 8'h00; ctrl_i = 0; idle_i = 0; viol_i = 0; bypass_i = 0;
    #2;
    check(K285N, "R8 no change before edge");
    @(posedge clk_i);
    @(negedge clk_i);
    check(10'b0110001011, "R8 R2 D.0.0 pos bit order");
  endtask

  initial begin
    t_reset();
    t_data();
    t_ctrl();
    t_bad_ctrl();
    t_idle();
    t_viol();
    t_bypass();
    t_priority();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule